// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a free-running 40-bit nanosecond time of day for precision time protocol timestamping. Every core clock (nominally 8 ns) the count advances by a fixed 8 ns step. A 32-bit sub-nanosecond fraction accumulator sits under the nanosecond count. A signed correction, held in sign-magnitude form, is added to or taken from that accumulator on each tick. The carry or borrow out of the accumulator moves the nanosecond count by one extra or one fewer nanosecond, so software can trim the rate in very fine steps.

Software reaches the block through a simple single-cycle register bus. Read data is registered and appears one cycle after the read strobe. A multi-word read is made coherent by a snapshot: reading the fraction word latches the whole nanosecond count, and later reads of the two nanosecond words return that latched value. A new time is loaded by writing the low nanosecond word and then the high word. The counter runs only while the halt bit of the control word is clear.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time (fraction and nanoseconds) is zero, the correction word (address 3) reads 0, and the control word (address 4) reads 0x8000_0000, meaning halt bit 31 is set.
- R2: While control bit 31 is 1, the time does not change.
- R3: While running with zero correction magnitude, each clock cycle adds exactly 8 ns and leaves the fraction unchanged.
- R4: With correction bit 31 = 0, each tick adds magnitude bits 30:0 to the 32-bit fraction. A carry out of the fraction adds 1 ns on top of the 8 ns step.
- R5: With correction bit 31 = 1, each tick subtracts the magnitude from the fraction. A borrow removes 1 ns from the 8 ns step.
- R6: The 40-bit nanosecond count wraps modulo 2^40 and keeps counting from zero.
- R7: Address 2 returns nanosecond bits 39:32 in bits 7:0, and bits 31:8 read as zero.
- R8: A read of address 0 returns the fraction and latches the full nanosecond count. Reads of address 1 (bits 31:0) and address 2 return the latched value, even if the live time has changed since.
- R9: Writing address 1 only stages the low word and leaves the time unchanged. Writing address 2 loads {wdata[7:0], staged low word} as the new time in that cycle and clears the fraction to zero.
- R10: The correction word (address 3) and the control word (address 4) read back the last value written. Writing 0 to the control word starts the counter.
- R11: Writes to address 0 have no effect on the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, one tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |

## Verification
The counter is run for known numbers of ticks by starting it and halting it a fixed number of cycles later. The frozen time is then compared with a bench model. A zero correction isolates the fixed step. A positive quarter-nanosecond correction shows that carries add time, and a negative one shows that borrows remove it. A load just below 2^40 exposes the wrap. Loading a new time between the fraction read and the word reads separates a true snapshot from a live read. Staged-only and fraction-word writes are checked to show they leave the time untouched.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FRAC = 3'd0,
    A_NSLO = 3'd1,
    A_NSHI = 3'd2,
    A_INC  = 3'd3,
    A_CTRL = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int NS_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] inc_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              run_o,
  output logic              load_o,
  output logic [NS_W-1:0]   load_ns_o
);
  localparam int HI_W = NS_W - DATA_W;

  logic [DATA_W-1:0] inc_q, ctrl_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q  <= '0;
      ctrl_q <= {1'b1, {(DATA_W-1){1'b0}}};
      lo_q   <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_INC:   inc_q  <= wdata_i;
        A_CTRL:  ctrl_q <= wdata_i;
        A_NSLO:  lo_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign inc_o     = inc_q;
  assign ctrl_o    = ctrl_q;
  assign run_o     = ~ctrl_q[DATA_W-1];
  assign load_o    = wr_en_i && (addr_i == A_NSHI);
  assign load_ns_o = {wdata_i[HI_W-1:0], lo_q};
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              sign_i,
  input  logic [FRAC_W-2:0] mag_i,
  input  logic              load_i,
  input  logic [NS_W-1:0]   load_ns_i,
  output logic [NS_W-1:0]   ns_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam logic [NS_W-1:0] STEP = NS_W'(STEP_NS);

  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   sum, dif, mag_x;
  logic [NS_W-1:0]   adj;
  logic [FRAC_W-1:0] frac_nx;

  always_comb begin
    mag_x = {2'b00, mag_i};
    sum   = {1'b0, frac_q} + mag_x;
    dif   = {1'b0, frac_q} - mag_x;
    if (sign_i) begin
      frac_nx = dif[FRAC_W-1:0];
      adj     = dif[FRAC_W] ? STEP - 1'b1 : STEP;
    end else begin
      frac_nx = sum[FRAC_W-1:0];
      adj     = sum[FRAC_W] ? STEP + 1'b1 : STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      ns_q   <= load_ns_i;
      frac_q <= '0;
    end else if (run_i) begin
      ns_q   <= ns_q + adj;
      frac_q <= frac_nx;
    end
  end

  assign ns_o   = ns_q;
  assign frac_o = frac_q;
endmodule

// File: rtl/ptp_tod_rdport.sv
module ptp_tod_rdport
  import ptp_tod_pkg::*;
#(
  parameter int NS_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [DATA_W-1:0] frac_i,
  input  logic [DATA_W-1:0] inc_i,
  input  logic [DATA_W-1:0] ctrl_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = NS_W - DATA_W;

  logic [NS_W-1:0]   snap_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        A_FRAC: begin
          rdata_q <= frac_i;
          snap_q  <= ns_i;
        end
        A_NSLO:  rdata_q <= snap_q[DATA_W-1:0];
        A_NSHI:  rdata_q <= {{(DATA_W-HI_W){1'b0}}, snap_q[NS_W-1:DATA_W]};
        A_INC:   rdata_q <= inc_i;
        A_CTRL:  rdata_q <= ctrl_i;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int NS_W    = 40,
  parameter int STEP_NS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] inc_q, ctrl_q, frac_q;
  logic [NS_W-1:0]   ns_q, load_ns;
  logic              run, load, inc_sign;

  ptp_tod_regs #(.NS_W(NS_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .inc_o(inc_q), .ctrl_o(ctrl_q), .run_o(run),
    .load_o(load), .load_ns_o(load_ns)
  );

  assign inc_sign = inc_q[DATA_W-1];

  ptp_tod_core #(.NS_W(NS_W), .FRAC_W(DATA_W), .STEP_NS(STEP_NS)) u_core (
    .clk_i, .rst_ni, .run_i(run), .sign_i(inc_sign),
    .mag_i(inc_q[DATA_W-2:0]), .load_i(load), .load_ns_i(load_ns),
    .ns_o(ns_q), .frac_o(frac_q)
  );

  ptp_tod_rdport #(.NS_W(NS_W)) u_rd (
    .clk_i, .rst_ni, .rd_en_i, .addr_i,
    .ns_i(ns_q), .frac_i(frac_q), .inc_i(inc_q), .ctrl_i(ctrl_q),
    .rdata_o
  );
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk
  import ptp_tod_pkg::*;
#(
  parameter int NS_W    = 40,
  parameter int STEP_NS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NS_W-1:0]   ns_q,
  input logic [DATA_W-1:0] frac_q,
  input logic              run,
  input logic              load,
  input logic              inc_sign
);
  localparam logic [NS_W-1:0] STEP = NS_W'(STEP_NS);

  logic [NS_W-1:0] ns_prev, delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ns_prev <= '0;
    else         ns_prev <= ns_q;
  end
  assign delta = ns_q - ns_prev;

  // R2
  halted_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !load) |=> ($stable(ns_q) && $stable(frac_q)));

  // R4
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !load && !inc_sign) |=> (delta == STEP || delta == STEP + 1'b1));

  // R5
  neg_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !load && inc_sign) |=> (delta == STEP || delta == STEP - 1'b1));

  // R7
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_NSHI) |=> (rdata_o[DATA_W-1:NS_W-DATA_W] == '0));

  // R9
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_NSHI) |=> (frac_q == '0));

  // R10
  ctrl_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL) |=> (run == !$past(wdata_i[DATA_W-1])));
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(.NS_W(NS_W), .STEP_NS(STEP_NS)) u_chk (.*);

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [39:0] m_ns;
  logic [31:0] m_frac;
  logic [31:0] m_inc;

  always #2 clk_i = ~clk_i;

  ptp_tod_counter u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic model_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      logic [32:0] t;
      if (m_inc[31]) begin
        t = {1'b0, m_frac} - {2'b0, m_inc[30:0]};
        m_ns = m_ns + 40'd8 - {39'd0, t[32]};
      end else begin
        t = {1'b0, m_frac} + {2'b0, m_inc[30:0]};
        m_ns = m_ns + 40'd8 + {39'd0, t[32]};
      end
      m_frac = t[31:0];
    end
  endtask

  task automatic run_ticks(input int n);
    bus_write(3'd4, 32'h0);
    repeat (n - 1) @(negedge clk_i);
    bus_write(3'd4, 32'h8000_0000);
    model_ticks(n);
  endtask

  task automatic set_inc(input logic [31:0] v);
    bus_write(3'd3, v);
    m_inc = v;
  endtask

  task automatic load_time(input logic [39:0] t, input logic [23:0] junk);
    bus_write(3'd1, t[31:0]);
    bus_write(3'd2, {junk, t[39:32]});
    m_ns = t; m_frac = '0;
  endtask

  task automatic check_time(input string req);
    logic [31:0] f, lo, hi;
    bus_read(3'd0, f);
    bus_read(3'd1, lo);
    bus_read(3'd2, hi);
    chk(req, f, m_frac);
    chk(req, lo, m_ns[31:0]);
    chk(req, hi, {24'd0, m_ns[39:32]});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(3'd3, d); chk("R1 inc", d, 32'h0);
    bus_read(3'd4, d); chk("R1 ctrl", d, 32'h8000_0000);
    check_time("R1 time");
  endtask

  task automatic t_halted;
    repeat (20) @(negedge clk_i);
    check_time("R2 halted");
  endtask

  task automatic t_nominal;
    run_ticks(100);
    check_time("R3 nominal");
    run_ticks(1);
    check_time("R3 single tick");
  endtask

  task automatic t_positive;
    load_time(40'd0, 24'd0);
    set_inc(32'h4000_0000);
    run_ticks(10);
    check_time("R4 positive carry");
    set_inc(32'h0000_0003);
    run_ticks(7);
    check_time("R4 small magnitude");
  endtask

  task automatic t_negative;
    load_time(40'd1000, 24'd0);
    set_inc(32'hC000_0000);
    run_ticks(8);
    check_time("R5 negative borrow");
  endtask

  task automatic t_wrap;
    set_inc(32'h0);
    load_time(40'hFF_FFFF_FFF0, 24'd0);
    run_ticks(3);
    check_time("R6 wrap");
  endtask

  task automatic t_hi_bits;
    load_time(40'h12_3456_789A, 24'hABCDEF);
    check_time("R7 high bits zero");
  endtask

  task automatic t_snapshot;
    logic [31:0] f, lo, hi;
    load_time(40'h05_0000_1111, 24'd0);
    bus_read(3'd0, f);
    load_time(40'h0A_2222_0000, 24'd0);
    bus_read(3'd1, lo);
    bus_read(3'd2, hi);
    chk("R8 snapshot lo", lo, 32'h0000_1111);
    chk("R8 snapshot hi", hi, 32'h0000_0005);
    check_time("R8 fresh snapshot");
  endtask

  task automatic t_load;
    set_inc(32'h1234_5678);
    run_ticks(5);
    bus_write(3'd1, 32'hDEAD_BEEF);
    check_time("R9 staged low only");
    bus_write(3'd2, 32'h0000_0033);
    m_ns = {8'h33, 32'hDEAD_BEEF}; m_frac = '0;
    check_time("R9 load clears fraction");
  endtask

  task automatic t_readback;
    logic [31:0] d;
    set_inc(32'h8765_4321);
    bus_read(3'd3, d); chk("R10 inc readback", d, 32'h8765_4321);
    bus_write(3'd4, 32'h0);
    bus_read(3'd4, d); chk("R10 ctrl readback", d, 32'h0);
    bus_write(3'd4, 32'h8000_0000);
    model_ticks(2);
    check_time("R10 started by clear");
  endtask

  task automatic t_frac_write;
    bus_write(3'd0, 32'hFFFF_FFFF);
    check_time("R11 fraction write ignored");
  endtask

  initial begin
    m_ns = '0; m_frac = '0; m_inc = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_halted();
    t_nominal();
    t_positive();
    t_negative();
    t_wrap();
    t_hi_bits();
    t_snapshot();
    t_load();
    t_readback();
    t_frac_write();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule